// File: doc/BRIEF.md
# Selective Sharer-Tracking Coherence Directory Slice

This block is one slice of a coherence directory for a MESI-style protocol. It tracks which of N private caches hold each block. Tracking storage is split into two arrays. The tag array is large and gives every tracked block an entry. That entry holds a shared/exclusive state and one pointer field. The sharer array is smaller and holds full sharer bit vectors. A block gets a sharer entry only while two or more caches hold it at once. While a block is held by one exclusive owner, the pointer field names that owner. Once the block is shared, the same field names the sharer-array way that holds its vector. A reverse pointer in each sharer entry links it back to its tag slot.

The slice takes one request at a time through a valid/ready handshake. A request is a read, a write, or an eviction notice, together with a core number and a block address. Each request gets a single response. The response carries a forward flag with a core number, which says where the request must be forwarded. It also carries an invalidation mask with one bit per core. Both arrays use least-recently-used replacement.

When the sharer array runs out of room, a shared block falls back to one owner. Its tag entry survives the loss of the sharer entry. When a tag entry is evicted, every cache that holds the block is invalidated.

Top module: `selective_dir`

## Requirements
- R1: A request is accepted on a rising edge where reqValid and reqReady are both high. reqReady stays low from that edge until the response. rspValid is high for exactly one cycle, starting after the second rising edge that follows the accepting edge. fwdValid and invMask are zero whenever rspValid is low.
- R2: Op codes are 0 for read, 1 for write and 2 for eviction notice. A read or write to an untracked block allocates only a tag entry, in the exclusive state, with the requester as owner. If a free tag way exists, the response carries no forward and an empty invalidation mask.
- R3: A read by a core other than the owner of an exclusive block makes the block shared. It allocates a sharer entry holding the old owner and the requester, and forwards the request to the old owner.
- R4: A write by a core other than the owner of an exclusive block forwards the request to the old owner and makes the requester the new owner. A read or write by the owner itself gives no forward and no invalidation.
- R5: A write to a shared block invalidates every sharer except the writer. Bit i of invMask stands for core i. The write frees the sharer entry and leaves the block exclusive, owned by the writer, with no forward.
- R6: A read to a shared block adds the requester to the sharer vector, with no forward and no invalidation.
- R7: The tag set is the low log2(TAG_SETS) bits of the block address. A miss into a full tag set evicts the least recently used way. Reads and writes that hit or allocate count as a use. An exclusive victim invalidates its owner. A shared victim invalidates all its sharers and frees its sharer entry.
- R8: An upgrade into a full sharer set evicts the least recently used sharer entry. Allocations and shared read hits count as a use. The evicted block keeps its tag and becomes exclusive, owned by its lowest-numbered sharer. Its other sharers appear in the same response's invMask.
- R9: An eviction notice from the owner of an exclusive block frees its tag. An eviction notice from a non-owner, or for an untracked block, changes nothing, and its response has no forward and an empty mask.
- R10: An eviction notice for a shared block clears the sender's sharer bit. If one sharer remains, the block stays shared. When the last sharer leaves, both the tag entry and the sharer entry are freed.
- R11: The sharer set is the low log2(DATA_SETS) bits of the tag set. Blocks that map to different sharer sets never displace each other's sharer entries.
- R12: A sharer entry is valid only while its block is shared. Its vector is never empty, and its reverse pointer names a valid shared tag entry whose pointer selects that sharer way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Slice can take a request |
| reqOp | input | 2 | 0 read, 1 write, 2 eviction notice |
| reqCore | input | log2(NCORES) | Requesting core |
| reqAddr | input | ADDR_W | Block address |
| rspValid | output | 1 | Response valid for one cycle |
| fwdValid | output | 1 | Request must be forwarded |
| fwdCore | output | log2(NCORES) | Forward target core |
| invMask | output | NCORES | Cores to invalidate |

## Verification
A corrupted pointer field or a stale link between the two arrays does not show up right away. It shows up on the next request to the affected block, as a forward to the wrong core or as a wrong invalidation mask. A lost or wrong replacement age shows up on the next miss or upgrade into that set, as a wrong victim in invMask. A sharer entry that is not freed shows up later, when an upgrade in the same sharer set evicts an unexpected block. For that reason the bench replays long request streams against an arithmetic model. The streams crowd a few sets, so that any divergence reaches the ports within a few requests.

// File: rtl/sdir_pkg.sv
package sdir_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_DROP  = 2'd2
  } reqOp_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_TAG  = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  typedef struct packed {
    logic capture;
    logic probe;
    logic commit;
  } strobe_t;

endpackage

// File: rtl/sdir_ctrl.sv
module sdir_ctrl
  import sdir_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    reqReady,
  output strobe_t stb
);

  phase_e phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    case (phase)
      PH_IDLE: if (reqValid) phaseNext = PH_TAG;
      PH_TAG:  phaseNext = PH_DATA;
      PH_DATA: phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assign reqReady    = (phase == PH_IDLE);
  assign stb.capture = reqReady && reqValid;
  assign stb.probe   = (phase == PH_TAG);
  assign stb.commit  = (phase == PH_DATA);

  // R1
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (!reqReady ##1 !reqReady));

endmodule

// File: rtl/sdir_datapath.sv
module sdir_datapath
  import sdir_pkg::*;
#(
  parameter int NCORES    = 4,
  parameter int TAG_SETS  = 4,
  parameter int TAG_WAYS  = 2,
  parameter int DATA_SETS = 2,
  parameter int DATA_WAYS = 2,
  parameter int ADDR_W    = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  input  logic [1:0]                reqOp,
  input  logic [$clog2(NCORES)-1:0] reqCore,
  input  logic [ADDR_W-1:0]         reqAddr,
  output logic                      rspValid,
  output logic                      fwdValid,
  output logic [$clog2(NCORES)-1:0] fwdCore,
  output logic [NCORES-1:0]         invMask
);

  localparam int CORE_W = $clog2(NCORES);
  localparam int TSET_W = $clog2(TAG_SETS);
  localparam int TWAY_W = $clog2(TAG_WAYS);
  localparam int DSET_W = $clog2(DATA_SETS);
  localparam int DWAY_W = $clog2(DATA_WAYS);
  localparam int TAG_W  = ADDR_W - TSET_W;
  localparam int PTR_W  = (CORE_W > DWAY_W) ? CORE_W : DWAY_W;

  typedef struct packed {
    logic             valid;
    logic             shared;
    logic [TAG_W-1:0] tag;
    logic [PTR_W-1:0] ptr;
  } tagEnt_t;

  typedef struct packed {
    logic              valid;
    logic [NCORES-1:0] sharers;
    logic [TSET_W-1:0] rset;
    logic [TWAY_W-1:0] rway;
  } dataEnt_t;

  tagEnt_t           tagMem  [TAG_SETS][TAG_WAYS];
  logic [TWAY_W-1:0] tagAge  [TAG_SETS][TAG_WAYS];
  dataEnt_t          dataMem [DATA_SETS][DATA_WAYS];
  logic [DWAY_W-1:0] dataAge [DATA_SETS][DATA_WAYS];

  reqOp_e            reqOpQ;
  logic [CORE_W-1:0] reqCoreQ;
  logic [ADDR_W-1:0] reqAddrQ;
  logic              hitQ;
  logic [TWAY_W-1:0] hitWayQ, victWayQ;

  function automatic logic [CORE_W-1:0] lowestCore(input logic [NCORES-1:0] v);
    lowestCore = '0;
    for (int i = NCORES - 1; i >= 0; i--)
      if (v[i]) lowestCore = CORE_W'(i);
  endfunction

  // ---------------- tag probe (first lookup cycle) ----------------
  logic [TSET_W-1:0] pSet;
  logic [TAG_W-1:0]  pTag;
  logic              probeHit, tFound;
  logic [TWAY_W-1:0] probeHitWay, probeVict;

  assign pSet = reqAddrQ[TSET_W-1:0];
  assign pTag = reqAddrQ[ADDR_W-1:TSET_W];

  always_comb begin
    probeHit    = 1'b0;
    probeHitWay = '0;
    probeVict   = '0;
    tFound      = 1'b0;
    for (int j = 0; j < TAG_WAYS; j++)
      if (tagMem[pSet][j].valid && tagMem[pSet][j].tag == pTag) begin
        probeHit    = 1'b1;
        probeHitWay = TWAY_W'(j);
      end
    for (int j = 0; j < TAG_WAYS; j++)
      if (!tFound && !tagMem[pSet][j].valid) begin
        tFound    = 1'b1;
        probeVict = TWAY_W'(j);
      end
    if (!tFound)
      for (int j = 0; j < TAG_WAYS; j++)
        if (tagAge[pSet][j] == TWAY_W'(TAG_WAYS - 1)) probeVict = TWAY_W'(j);
  end

  // ---------------- commit (second lookup cycle) ----------------
  logic [TSET_W-1:0] cSet;
  logic [TAG_W-1:0]  cTag;
  logic [DSET_W-1:0] cDSet;
  tagEnt_t           curEnt, victEnt;
  dataEnt_t          curData, dvEnt;
  logic [CORE_W-1:0] curOwner, keeper;
  logic [DWAY_W-1:0] curDWay, dVict;
  logic [NCORES-1:0] reqBit, ownerBit, remain;
  logic              dFound;

  assign cSet     = reqAddrQ[TSET_W-1:0];
  assign cTag     = reqAddrQ[ADDR_W-1:TSET_W];
  assign cDSet    = cSet[DSET_W-1:0];
  assign curEnt   = tagMem[cSet][hitWayQ];
  assign victEnt  = tagMem[cSet][victWayQ];
  assign curOwner = curEnt.ptr[CORE_W-1:0];
  assign curDWay  = curEnt.ptr[DWAY_W-1:0];
  assign curData  = dataMem[cDSet][curDWay];
  assign reqBit   = NCORES'(1) << reqCoreQ;
  assign ownerBit = NCORES'(1) << curOwner;
  assign remain   = curData.sharers & ~reqBit;
  assign dvEnt    = dataMem[cDSet][dVict];
  assign keeper   = lowestCore(dvEnt.sharers);

  always_comb begin
    dVict  = '0;
    dFound = 1'b0;
    for (int j = 0; j < DATA_WAYS; j++)
      if (!dFound && !dataMem[cDSet][j].valid) begin
        dFound = 1'b1;
        dVict  = DWAY_W'(j);
      end
    if (!dFound)
      for (int j = 0; j < DATA_WAYS; j++)
        if (dataAge[cDSet][j] == DWAY_W'(DATA_WAYS - 1)) dVict = DWAY_W'(j);
  end

  logic              tagWrAEn, tagWrBEn, tagTouchEn, dataWrEn, dataTouchEn;
  logic [TWAY_W-1:0] tagWrAWay, tagWrBWay, touchWay;
  logic [TSET_W-1:0] tagWrBSet;
  tagEnt_t           tagWrAEnt, tagWrBEnt;
  logic [DWAY_W-1:0] dataWrWay;
  dataEnt_t          dataWrEnt;
  logic              nFwdV;
  logic [CORE_W-1:0] nFwdC;
  logic [NCORES-1:0] nInv;

  always_comb begin
    tagWrAEn = 1'b0; tagWrAWay = hitWayQ; tagWrAEnt = curEnt;
    tagWrBEn = 1'b0; tagWrBSet = dvEnt.rset; tagWrBWay = dvEnt.rway;
    tagWrBEnt = tagMem[dvEnt.rset][dvEnt.rway];
    tagTouchEn = 1'b0; touchWay = hitWayQ;
    dataWrEn = 1'b0; dataWrWay = curDWay; dataWrEnt = curData; dataTouchEn = 1'b0;
    nFwdV = 1'b0; nFwdC = '0; nInv = '0;
    if (stb.commit) begin
      if (!hitQ) begin
        if (reqOpQ == OP_READ || reqOpQ == OP_WRITE) begin
          if (victEnt.valid) begin
            if (victEnt.shared) begin
              nInv      = dataMem[cDSet][victEnt.ptr[DWAY_W-1:0]].sharers;
              dataWrEn  = 1'b1;
              dataWrWay = victEnt.ptr[DWAY_W-1:0];
              dataWrEnt = '0;
            end else begin
              nInv = NCORES'(1) << victEnt.ptr[CORE_W-1:0];
            end
          end
          tagWrAEn   = 1'b1;
          tagWrAWay  = victWayQ;
          tagWrAEnt  = '{valid: 1'b1, shared: 1'b0, tag: cTag, ptr: PTR_W'(reqCoreQ)};
          tagTouchEn = 1'b1;
          touchWay   = victWayQ;
        end
      end else begin
        case (reqOpQ)
          OP_READ: begin
            tagTouchEn = 1'b1;
            if (curEnt.shared) begin
              dataWrEn            = 1'b1;
              dataWrEnt.sharers   = curData.sharers | reqBit;
              dataTouchEn         = 1'b1;
            end else if (curOwner != reqCoreQ) begin
              nFwdV = 1'b1;
              nFwdC = curOwner;
              if (dvEnt.valid) begin
                nInv                = dvEnt.sharers & ~(NCORES'(1) << keeper);
                tagWrBEn            = 1'b1;
                tagWrBEnt.shared    = 1'b0;
                tagWrBEnt.ptr       = PTR_W'(keeper);
              end
              dataWrEn    = 1'b1;
              dataWrWay   = dVict;
              dataWrEnt   = '{valid: 1'b1, sharers: reqBit | ownerBit, rset: cSet, rway: hitWayQ};
              dataTouchEn = 1'b1;
              tagWrAEn         = 1'b1;
              tagWrAEnt.shared = 1'b1;
              tagWrAEnt.ptr    = PTR_W'(dVict);
            end
          end
          OP_WRITE: begin
            tagTouchEn = 1'b1;
            if (curEnt.shared) begin
              nInv             = remain;
              dataWrEn         = 1'b1;
              dataWrEnt        = '0;
              tagWrAEn         = 1'b1;
              tagWrAEnt.shared = 1'b0;
              tagWrAEnt.ptr    = PTR_W'(reqCoreQ);
            end else if (curOwner != reqCoreQ) begin
              nFwdV         = 1'b1;
              nFwdC         = curOwner;
              tagWrAEn      = 1'b1;
              tagWrAEnt.ptr = PTR_W'(reqCoreQ);
            end
          end
          OP_DROP: begin
            if (curEnt.shared) begin
              dataWrEn = 1'b1;
              if (remain == '0) begin
                dataWrEnt       = '0;
                tagWrAEn        = 1'b1;
                tagWrAEnt.valid = 1'b0;
              end else begin
                dataWrEnt.sharers = remain;
              end
            end else if (curOwner == reqCoreQ) begin
              tagWrAEn        = 1'b1;
              tagWrAEnt.valid = 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqOpQ   <= OP_READ;
      reqCoreQ <= '0;
      reqAddrQ <= '0;
      hitQ     <= 1'b0;
      hitWayQ  <= '0;
      victWayQ <= '0;
      rspValid <= 1'b0;
      fwdValid <= 1'b0;
      fwdCore  <= '0;
      invMask  <= '0;
      for (int s = 0; s < TAG_SETS; s++)
        for (int j = 0; j < TAG_WAYS; j++) begin
          tagMem[s][j] <= '0;
          tagAge[s][j] <= TWAY_W'(j);
        end
      for (int s = 0; s < DATA_SETS; s++)
        for (int j = 0; j < DATA_WAYS; j++) begin
          dataMem[s][j] <= '0;
          dataAge[s][j] <= DWAY_W'(j);
        end
    end else begin
      if (stb.capture) begin
        reqOpQ   <= reqOp_e'(reqOp);
        reqCoreQ <= reqCore;
        reqAddrQ <= reqAddr;
      end
      if (stb.probe) begin
        hitQ     <= probeHit;
        hitWayQ  <= probeHitWay;
        victWayQ <= probeVict;
      end
      rspValid <= stb.commit;
      fwdValid <= nFwdV;
      fwdCore  <= nFwdC;
      invMask  <= nInv;
      if (tagWrBEn) tagMem[tagWrBSet][tagWrBWay] <= tagWrBEnt;
      if (tagWrAEn) tagMem[cSet][tagWrAWay] <= tagWrAEnt;
      if (dataWrEn) dataMem[cDSet][dataWrWay] <= dataWrEnt;
      if (tagTouchEn)
        for (int j = 0; j < TAG_WAYS; j++) begin
          if (TWAY_W'(j) == touchWay) tagAge[cSet][j] <= '0;
          else if (tagAge[cSet][j] < tagAge[cSet][touchWay])
            tagAge[cSet][j] <= tagAge[cSet][j] + TWAY_W'(1);
        end
      if (dataTouchEn)
        for (int j = 0; j < DATA_WAYS; j++) begin
          if (DWAY_W'(j) == dataWrWay) dataAge[cDSet][j] <= '0;
          else if (dataAge[cDSet][j] < dataAge[cDSet][dataWrWay])
            dataAge[cDSet][j] <= dataAge[cDSet][j] + DWAY_W'(1);
        end
    end
  end

  // R1
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!fwdValid && invMask == '0));

  // R1
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> ##3 rspValid);

  // R4
  fwd_not_self_chk: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> (fwdCore != reqCoreQ));

  for (genvar gs = 0; gs < DATA_SETS; gs++) begin : g_dset
    for (genvar gw = 0; gw < DATA_WAYS; gw++) begin : g_dway
      // R12
      sharers_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
        dataMem[gs][gw].valid |-> (dataMem[gs][gw].sharers != '0));
      // R12
      reverse_link_chk: assert property (@(posedge clk) disable iff (!rstN)
        dataMem[gs][gw].valid |->
          (tagMem[dataMem[gs][gw].rset][dataMem[gs][gw].rway].valid &&
           tagMem[dataMem[gs][gw].rset][dataMem[gs][gw].rway].shared &&
           tagMem[dataMem[gs][gw].rset][dataMem[gs][gw].rway].ptr[DWAY_W-1:0] == DWAY_W'(gw)));
    end
  end

endmodule

// File: rtl/selective_dir.sv
module selective_dir
  import sdir_pkg::*;
#(
  parameter int NCORES    = 4,
  parameter int TAG_SETS  = 4,
  parameter int TAG_WAYS  = 2,
  parameter int DATA_SETS = 2,
  parameter int DATA_WAYS = 2,
  parameter int ADDR_W    = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  output logic                      reqReady,
  input  logic [1:0]                reqOp,
  input  logic [$clog2(NCORES)-1:0] reqCore,
  input  logic [ADDR_W-1:0]         reqAddr,
  output logic                      rspValid,
  output logic                      fwdValid,
  output logic [$clog2(NCORES)-1:0] fwdCore,
  output logic [NCORES-1:0]         invMask
);

  strobe_t stb;

  sdir_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .stb      (stb)
  );

  sdir_datapath #(
    .NCORES    (NCORES),
    .TAG_SETS  (TAG_SETS),
    .TAG_WAYS  (TAG_WAYS),
    .DATA_SETS (DATA_SETS),
    .DATA_WAYS (DATA_WAYS),
    .ADDR_W    (ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqOp    (reqOp),
    .reqCore  (reqCore),
    .reqAddr  (reqAddr),
    .rspValid (rspValid),
    .fwdValid (fwdValid),
    .fwdCore  (fwdCore),
    .invMask  (invMask)
  );

endmodule

// File: tb/selective_dir_tb.sv
`timescale 1ns/1ps
module selective_dir_tb;

  localparam int NC = 4;
  localparam int TS = 4;
  localparam int TW = 2;
  localparam int DS = 2;
  localparam int DW = 2;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqOp = '0;
  logic [1:0]    reqCore = '0;
  logic [AW-1:0] reqAddr = '0;
  logic          reqReady, rspValid, fwdValid;
  logic [1:0]    fwdCore;
  logic [NC-1:0] invMask;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  selective_dir #(.NCORES(NC), .TAG_SETS(TS), .TAG_WAYS(TW), .DATA_SETS(DS),
                  .DATA_WAYS(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqCore(reqCore), .reqAddr(reqAddr), .rspValid(rspValid),
    .fwdValid(fwdValid), .fwdCore(fwdCore), .invMask(invMask));

  // arithmetic reference of the requirements
  bit            mTV  [TS][TW];
  int            mTTag[TS][TW];
  bit            mTSh [TS][TW];
  int            mTPtr[TS][TW];
  int            mTTs [TS][TW];
  bit            mDV  [DS][DW];
  logic [NC-1:0] mDSh [DS][DW];
  int            mDRs [DS][DW];
  int            mDRw [DS][DW];
  int            mDTs [DS][DW];
  int            stamp = 0;

  function automatic int tagVictim(input int s);
    int best;
    for (int w = 0; w < TW; w++) if (!mTV[s][w]) return w;
    best = 0;
    for (int w = 1; w < TW; w++) if (mTTs[s][w] < mTTs[s][best]) best = w;
    return best;
  endfunction

  function automatic int dataVictim(input int d);
    int best;
    for (int w = 0; w < DW; w++) if (!mDV[d][w]) return w;
    best = 0;
    for (int w = 1; w < DW; w++) if (mDTs[d][w] < mDTs[d][best]) best = w;
    return best;
  endfunction

  task automatic modelOp(input int op, input int core, input int addr,
                         output bit ef, output int ec, output logic [NC-1:0] ei,
                         output string rid);
    int s, tg, d, hw, vw, p, dv, keep, rs, rw;
    logic [NC-1:0] bitR, ns;
    s = addr % TS; tg = addr / TS; d = s % DS;
    bitR = NC'(1) << core;
    ef = 0; ec = 0; ei = '0; hw = -1;
    for (int w = 0; w < TW; w++) if (mTV[s][w] && mTTag[s][w] == tg) hw = w;
    if (hw < 0) begin
      if (op == 2) begin rid = "R9"; return; end
      vw = tagVictim(s);
      rid = "R2";
      if (mTV[s][vw]) begin
        rid = "R7";
        if (mTSh[s][vw]) begin ei = mDSh[d][mTPtr[s][vw]]; mDV[d][mTPtr[s][vw]] = 0; end
        else ei = NC'(1) << mTPtr[s][vw];
      end
      mTV[s][vw] = 1; mTTag[s][vw] = tg; mTSh[s][vw] = 0; mTPtr[s][vw] = core;
      stamp++; mTTs[s][vw] = stamp;
      return;
    end
    p = mTPtr[s][hw];
    if (op == 0) begin
      stamp++; mTTs[s][hw] = stamp;
      if (mTSh[s][hw]) begin
        rid = "R6"; mDSh[d][p] = mDSh[d][p] | bitR; stamp++; mDTs[d][p] = stamp;
      end else if (p != core) begin
        rid = "R3"; ef = 1; ec = p;
        dv = dataVictim(d);
        if (mDV[d][dv]) begin
          rid = "R8";
          keep = 0;
          for (int i = NC - 1; i >= 0; i--) if (mDSh[d][dv][i]) keep = i;
          ei = mDSh[d][dv] & ~(NC'(1) << keep);
          rs = mDRs[d][dv]; rw = mDRw[d][dv];
          mTSh[rs][rw] = 0; mTPtr[rs][rw] = keep;
        end
        mDV[d][dv] = 1; mDSh[d][dv] = bitR | (NC'(1) << p); mDRs[d][dv] = s; mDRw[d][dv] = hw;
        stamp++; mDTs[d][dv] = stamp;
        mTSh[s][hw] = 1; mTPtr[s][hw] = dv;
      end else rid = "R4";
    end else if (op == 1) begin
      stamp++; mTTs[s][hw] = stamp;
      if (mTSh[s][hw]) begin
        rid = "R5"; ei = mDSh[d][p] & ~bitR; mDV[d][p] = 0; mTSh[s][hw] = 0; mTPtr[s][hw] = core;
      end else begin
        rid = "R4";
        if (p != core) begin ef = 1; ec = p; mTPtr[s][hw] = core; end
      end
    end else begin
      if (mTSh[s][hw]) begin
        rid = "R10"; ns = mDSh[d][p] & ~bitR;
        if (ns == '0) begin mDV[d][p] = 0; mTV[s][hw] = 0; end
        else mDSh[d][p] = ns;
      end else begin
        rid = "R9";
        if (p == core) mTV[s][hw] = 0;
      end
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doOp(input int op, input int core, input int addr, input string note);
    bit ef; int ec; logic [NC-1:0] ei; string rid; int waited;
    modelOp(op, core, addr, ef, ec, ei, rid);
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'(op); reqCore = 2'(core); reqAddr = AW'(addr);
    @(negedge clk);
    reqValid = 1'b0;
    waited = 1;
    chk(!reqReady && !rspValid, "R1", "busy after accept", int'(reqReady), 0);
    while (!rspValid && waited < 12) begin
      @(negedge clk);
      waited++;
    end
    // accepted at edge k; response appears after edge k+2 = third negedge
    chk(waited == 3, "R1", "response latency", waited, 3);
    chk(fwdValid == ef, {rid, note}, "fwdValid", int'(fwdValid), int'(ef));
    if (ef) chk(int'(fwdCore) == ec, {rid, note}, "fwdCore", int'(fwdCore), ec);
    chk(invMask == ei, {rid, note}, "invMask", int'(invMask), int'(ei));
    @(negedge clk);
    chk(!rspValid && !fwdValid && invMask == '0, "R1", "single-cycle response",
        int'(rspValid), 0);
  endtask

  function automatic int A(input int tg, input int s);
    return tg * TS + s;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !rspValid && !fwdValid && invMask == '0, "R1", "reset state",
        int'(reqReady), 1);

    // exclusive path: R2, R4
    doOp(0, 0, A(1, 0), " R2 miss");
    doOp(1, 1, A(1, 0), " R4 steal");
    doOp(0, 1, A(1, 0), " R4 self read");
    doOp(1, 1, A(1, 0), " R4 self write");
    // shared path: R3, R6, R5
    doOp(0, 2, A(1, 0), " R3 upgrade");
    doOp(0, 3, A(1, 0), " R6 join");
    doOp(1, 2, A(1, 0), " R5 write shared");
    // eviction notices: R9
    doOp(2, 0, A(1, 0), " R9 non-owner");
    doOp(2, 1, A(3, 3), " R9 untracked");
    doOp(1, 3, A(1, 0), " R9 unchanged owner");
    doOp(2, 3, A(1, 0), " R9 owner leaves");
    doOp(0, 1, A(1, 0), " R9 freed");
    // R10 lone sharer stays shared, last leaver frees
    doOp(0, 0, A(1, 0), " R10 setup");
    doOp(2, 1, A(1, 0), " R10 lone");
    doOp(1, 2, A(1, 0), " R10 lone still shared");
    doOp(0, 3, A(1, 0), " R10 reshare");
    doOp(2, 2, A(1, 0), " R10 leave");
    doOp(2, 3, A(1, 0), " R10 last leave");
    doOp(0, 1, A(1, 0), " R10 freed");
    // R7 tag LRU, exclusive and shared victims
    doOp(0, 0, A(1, 1), " R7");
    doOp(0, 1, A(2, 1), " R7");
    doOp(0, 0, A(1, 1), " R7 touch");
    doOp(0, 2, A(3, 1), " R7 evict");
    doOp(0, 3, A(3, 1), " R7 share");
    doOp(1, 1, A(1, 1), " R7");
    doOp(0, 0, A(2, 1), " R7 evict shared");
    // R8/R11: fill sharer set 0 from tag sets 0 and 2, set 1 untouched
    doOp(0, 0, A(2, 3), " R11 setup");
    doOp(0, 1, A(2, 3), " R11 set1 share");
    doOp(0, 2, A(1, 0), " R8 setup");
    doOp(0, 3, A(1, 0), " R8 share a");
    doOp(0, 0, A(1, 2), " R8 setup");
    doOp(0, 2, A(1, 2), " R8 share b");
    doOp(0, 1, A(1, 0), " R8 touch a");
    doOp(0, 2, A(2, 2), " R8 setup");
    doOp(0, 3, A(2, 2), " R8 data evict");
    doOp(0, 3, A(2, 3), " R11 set1 kept");
    doOp(1, 0, A(1, 2), " R8 survivor owner");
    doOp(1, 0, A(2, 2), " R12 free on write");
    doOp(0, 1, A(2, 2), " R12 realloc");

    // near-exhaustive stream over a crowded address space
    seed = 32'h1234_5678;
    for (int n = 0; n < 3000; n++) begin
      int op, core, addr, r;
      seed = seed * 32'd1664525 + 32'd1013904223;
      r = int'((seed >> 8) % 10);
      op = (r < 4) ? 0 : (r < 7) ? 1 : 2;
      core = int'((seed >> 12) % 4);
      addr = A(int'((seed >> 16) % 4), int'((seed >> 20) % 4));
      doOp(op, core, addr, " sweep");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule